// File: doc/BRIEF.md
# Sectored Instruction Cache Lookup Controller

This block is the tag and valid-state control path of a read-only, eight-way set-associative instruction cache split into two banks. It does not store instruction data. Each request carries a byte address. The block decides from a programmable address window whether the access is cacheable. It then looks up the tags of the addressed set and checks the valid bit of the 16-byte sector that holds the address. One cycle after it accepts the request, it returns one of four result codes.

Valid state is tracked per 128-bit sector rather than per line. A miss fetches the missing sector and every later sector up to the end of the 256-byte line, and never past it. The returned beats mark sectors valid one by one, in order. The block drives a write strobe with bank, set, way and sector, which tells the external data RAM where each beat goes. While that fill is running, a request for a sector that the fill will still deliver is reported as a prefetch hit, and no new fetch is issued. Only one fill may be in flight at a time. The way to replace comes from an external replacement input. Non-cacheable accesses go upstream as single-beat requests and never allocate.

Top module: `icl_top`

## Requirements
- R1: Address bits [3:0] are the byte within a sector and [7:4] the sector (0..15). Bit [8] selects one of two banks, [13:9] select one of 32 sets, and [31:14] form the tag. The same tag and set in the other bank is a separate line.
- R2: An address A is cacheable when cfgBase <= A <= cfgLimit. Any other address is answered with code 3 (bypass). It issues an upstream request with fillReqBypass=1, fillReqBeats=1 and the address with bits [3:0] cleared. It allocates nothing, and its returned beat raises no write strobe.
- R3: A cacheable request whose tag matches a valid way and whose sector is valid is answered with code 0 (hit) and that way, in the cycle after acceptance. This holds even while a fill is in flight.
- R4: A cacheable request that is neither a hit nor a prefetch hit is answered with code 2 (miss). It issues one upstream request with fillReqBypass=0, the address with bits [3:0] cleared, and fillReqBeats = 16 - sector, so the fill ends at the end of the line.
- R5: Each returned beat of a cacheable fill raises fillWrEn with the line's bank, set and way, and with sectors in ascending order from the missed sector. Those sectors then hit, and sectors below the missed sector stay invalid.
- R6: While a cacheable fill is in flight, a request to the same line for a sector at or above the fill's first sector that has not yet arrived is answered with code 1 (prefetch hit) and the fill's way. It issues no upstream request.
- R7: While a fill or bypass is in flight, reqReady is low for any request that would be a miss or a bypass. It returns high once the last beat has been taken.
- R8: A miss whose tag matches no valid way allocates the way given on victimWay. It clears all 16 sector valid bits of that way, so the line that was there before stops hitting.
- R9: A miss whose tag already matches a valid way (a partly filled line) refills that way, ignores victimWay, and keeps that way's valid sectors.
- R10: A synchronous reset clears every tag and sector valid bit in both banks and ends any fill in flight.
- R11: fillReqValid stays high with fillReqAddr unchanged until fillReqReady is seen high, and drops in the cycle after that.
- R12: A fill beat that arrives while no fill is in flight raises no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgBase | input | 32 | Lowest cacheable byte address |
| cfgLimit | input | 32 | Highest cacheable byte address |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Request byte address |
| reqReady | output | 1 | Request can be accepted this cycle |
| victimWay | input | 3 | Way to replace on allocation |
| respValid | output | 1 | Result valid (cycle after acceptance) |
| respCode | output | 2 | 0 hit, 1 prefetch hit, 2 miss, 3 bypass |
| respWay | output | 3 | Way holding or receiving the line |
| fillReqValid | output | 1 | Upstream fetch request |
| fillReqReady | input | 1 | Upstream accepts the fetch request |
| fillReqAddr | output | 32 | Sector-aligned start address of the fetch |
| fillReqBeats | output | 5 | Number of 128-bit beats requested |
| fillReqBypass | output | 1 | Fetch is non-cacheable |
| fillBeatValid | input | 1 | One 128-bit beat returned from upstream |
| fillWrEn | output | 1 | Write the current beat into the data RAM |
| fillWrBank | output | 1 | Bank of the beat being written |
| fillWrSet | output | 5 | Set of the beat being written |
| fillWrWay | output | 3 | Way of the beat being written |
| fillWrSector | output | 4 | Sector of the beat being written |

## Verification
The hardest situation to reach is a line whose sectors are mixed: some valid from an earlier partial fill, a refill in progress, and requests landing on sectors that are already there, still to come, or below the refill's start. The bench first misses in the middle of a line and, before any beat returns, sends a prefetch-hit request and a blocked request to another line. It then misses at sector 0 of the same line with a different victim input, so the refill has to reuse the way. Eviction is checked by filling a line completely and then missing with a new tag that maps to the same set and way, after which a formerly valid sector must miss.

// File: rtl/icl_pkg.sv
package icl_pkg;
  parameter int ADDR_W       = 32;
  parameter int WAYS         = 8;
  parameter int SETS         = 32;
  parameter int BANKS        = 2;
  parameter int SECTORS      = 16;
  parameter int SECTOR_BYTES = 16;

  localparam int WAY_W    = $clog2(WAYS);
  localparam int SET_W    = $clog2(SETS);
  localparam int BANK_W   = $clog2(BANKS);
  localparam int SEC_W    = $clog2(SECTORS);
  localparam int CNT_W    = $clog2(SECTORS + 1);
  localparam int SEC_LSB  = $clog2(SECTOR_BYTES);
  localparam int BANK_LSB = SEC_LSB + SEC_W;
  localparam int SET_LSB  = BANK_LSB + BANK_W;
  localparam int TAG_LSB  = SET_LSB + SET_W;
  localparam int TAG_W    = ADDR_W - TAG_LSB;
  localparam int LINE_W   = ADDR_W - BANK_LSB;
  localparam int IDX_W    = BANK_W + SET_W + WAY_W;
  localparam int ENTRIES  = BANKS * SETS * WAYS;

  typedef enum logic [1:0] {
    RC_HIT    = 2'd0,
    RC_PFHIT  = 2'd1,
    RC_MISS   = 2'd2,
    RC_BYPASS = 2'd3
  } respCode_e;

  typedef struct packed {
    logic              alloc;
    logic [BANK_W-1:0] allocBank;
    logic [SET_W-1:0]  allocSet;
    logic [WAY_W-1:0]  allocWay;
    logic [TAG_W-1:0]  allocTag;
    logic              mark;
    logic [BANK_W-1:0] markBank;
    logic [SET_W-1:0]  markSet;
    logic [WAY_W-1:0]  markWay;
    logic [SEC_W-1:0]  markSec;
  } iclStrobe_t;
endpackage

// File: rtl/icl_tag_store.sv
module icl_tag_store
  import icl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] lkBank,
  input  logic [SET_W-1:0]  lkSet,
  input  logic [TAG_W-1:0]  lkTag,
  input  logic [SEC_W-1:0]  lkSec,
  input  iclStrobe_t        stb,
  output logic              lkTagHit,
  output logic [WAY_W-1:0]  lkWay,
  output logic              lkSecValid
);
  logic [TAG_W-1:0]   tagMem [ENTRIES];
  logic [ENTRIES-1:0] tagVal;
  logic [SECTORS-1:0] secVal [ENTRIES];
  logic [WAYS-1:0]    hitVec;

  logic [IDX_W-1:0] allocIdx, markIdx, lkIdx;
  assign allocIdx = {stb.allocBank, stb.allocSet, stb.allocWay};
  assign markIdx  = {stb.markBank, stb.markSet, stb.markWay};

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    localparam logic [WAY_W-1:0] WV = WAY_W'(w);
    assign hitVec[w] = tagVal[{lkBank, lkSet, WV}] &&
                       (tagMem[{lkBank, lkSet, WV}] == lkTag);
  end

  always_comb begin
    lkWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) lkWay = WAY_W'(w);
  end

  assign lkTagHit   = |hitVec;
  assign lkIdx      = {lkBank, lkSet, lkWay};
  assign lkSecValid = lkTagHit && secVal[lkIdx][lkSec];

  always_ff @(posedge clk) begin
    if (stb.alloc) tagMem[allocIdx] <= stb.allocTag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tagVal <= '0;
      for (int i = 0; i < ENTRIES; i++) secVal[i] <= '0;
    end else begin
      if (stb.alloc) begin
        tagVal[allocIdx] <= 1'b1;
        secVal[allocIdx] <= '0;
      end
      if (stb.mark) secVal[markIdx][stb.markSec] <= 1'b1;
    end
  end

  // R1: one tag never sits in two ways of one set
  p_onehot_hit_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(hitVec));
  // R5: beats only land in a way that holds an allocated tag
  p_mark_allocated_r5: assert property (@(posedge clk) disable iff (rst)
    stb.mark |-> tagVal[markIdx]);
  // R8: clearing a way and filling it never collide
  p_alloc_mark_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(stb.alloc && stb.mark));
endmodule

// File: rtl/icl_ctrl.sv
module icl_ctrl
  import icl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  input  logic [WAY_W-1:0]  victimWay,
  input  logic              lkTagHit,
  input  logic [WAY_W-1:0]  lkWay,
  input  logic              lkSecValid,
  output iclStrobe_t        stb,
  output logic              respValid,
  output logic [1:0]        respCode,
  output logic [WAY_W-1:0]  respWay,
  output logic              fillReqValid,
  input  logic              fillReqReady,
  output logic [ADDR_W-1:0] fillReqAddr,
  output logic [CNT_W-1:0]  fillReqBeats,
  output logic              fillReqBypass,
  input  logic              fillBeatValid,
  output logic              fillWrEn
);
  logic              busy, fillBypass;
  logic [LINE_W-1:0] fillLine;
  logic [WAY_W-1:0]  fillWay;
  logic [SEC_W-1:0]  curSec, startSec;

  logic              cacheable, secHit, pfHit, accept, startFill, beatTake, lastBeat;
  logic [SEC_W-1:0]  reqSec;
  logic [LINE_W-1:0] reqLine;
  logic [WAY_W-1:0]  missWay;
  respCode_e         code;

  assign reqSec    = reqAddr[SEC_LSB +: SEC_W];
  assign reqLine   = reqAddr[ADDR_W-1:BANK_LSB];
  assign cacheable = (reqAddr >= cfgBase) && (reqAddr <= cfgLimit);
  assign secHit    = cacheable && lkSecValid;
  assign pfHit     = cacheable && busy && !fillBypass && !secHit &&
                     (reqLine == fillLine) && (reqSec >= startSec);
  assign reqReady  = !busy || secHit || pfHit;
  assign accept    = reqValid && reqReady;
  assign startFill = accept && !secHit && !pfHit;
  assign missWay   = lkTagHit ? lkWay : victimWay;
  assign beatTake  = busy && fillBeatValid;
  assign lastBeat  = beatTake && (fillBypass || (curSec == SEC_W'(SECTORS - 1)));
  assign fillWrEn  = beatTake && !fillBypass;

  always_comb begin
    if (!cacheable)  code = RC_BYPASS;
    else if (secHit) code = RC_HIT;
    else if (pfHit)  code = RC_PFHIT;
    else             code = RC_MISS;
  end

  always_comb begin
    stb           = '0;
    stb.alloc     = startFill && cacheable && !lkTagHit;
    stb.allocBank = reqAddr[BANK_LSB +: BANK_W];
    stb.allocSet  = reqAddr[SET_LSB +: SET_W];
    stb.allocWay  = victimWay;
    stb.allocTag  = reqAddr[ADDR_W-1:TAG_LSB];
    stb.mark      = fillWrEn;
    stb.markBank  = fillLine[0 +: BANK_W];
    stb.markSet   = fillLine[BANK_W +: SET_W];
    stb.markWay   = fillWay;
    stb.markSec   = curSec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; fillBypass <= 1'b0; fillLine <= '0; fillWay <= '0;
      curSec <= '0; startSec <= '0;
      respValid <= 1'b0; respCode <= '0; respWay <= '0;
      fillReqValid <= 1'b0; fillReqAddr <= '0; fillReqBeats <= '0; fillReqBypass <= 1'b0;
    end else begin
      respValid <= accept;
      if (accept) begin
        respCode <= code;
        case (code)
          RC_HIT:   respWay <= lkWay;
          RC_PFHIT: respWay <= fillWay;
          RC_MISS:  respWay <= missWay;
          default:  respWay <= '0;
        endcase
      end
      if (fillReqValid && fillReqReady) fillReqValid <= 1'b0;
      if (startFill) begin
        busy          <= 1'b1;
        fillBypass    <= !cacheable;
        fillLine      <= reqLine;
        fillWay       <= missWay;
        curSec        <= reqSec;
        startSec      <= reqSec;
        fillReqValid  <= 1'b1;
        fillReqAddr   <= {reqAddr[ADDR_W-1:SEC_LSB], {SEC_LSB{1'b0}}};
        fillReqBeats  <= cacheable ? (CNT_W'(SECTORS) - CNT_W'(reqSec)) : CNT_W'(1);
        fillReqBypass <= !cacheable;
      end else if (beatTake) begin
        if (lastBeat) busy <= 1'b0;
        else          curSec <= curSec + 1'b1;
      end
    end
  end

  // R7: no new fetch is started while one is in flight
  p_one_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && accept) |-> (secHit || pfHit));
  // R3: every accepted request is answered next cycle
  p_resp_next_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> respValid);
  // R11: upstream request held stable until taken
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (fillReqValid && !fillReqReady) |=> (fillReqValid && $stable(fillReqAddr)));
  // R2: out-of-window requests are answered as bypass
  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !cacheable) |=> (respCode == RC_BYPASS && fillReqBypass));
endmodule

// File: rtl/icl_top.sv
module icl_top
  import icl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  input  logic [WAY_W-1:0]  victimWay,
  output logic              respValid,
  output logic [1:0]        respCode,
  output logic [WAY_W-1:0]  respWay,
  output logic              fillReqValid,
  input  logic              fillReqReady,
  output logic [ADDR_W-1:0] fillReqAddr,
  output logic [CNT_W-1:0]  fillReqBeats,
  output logic              fillReqBypass,
  input  logic              fillBeatValid,
  output logic              fillWrEn,
  output logic [BANK_W-1:0] fillWrBank,
  output logic [SET_W-1:0]  fillWrSet,
  output logic [WAY_W-1:0]  fillWrWay,
  output logic [SEC_W-1:0]  fillWrSector
);
  iclStrobe_t       stb;
  logic             lkTagHit, lkSecValid;
  logic [WAY_W-1:0] lkWay;

  icl_ctrl u_ctrl (
    .clk, .rst, .cfgBase, .cfgLimit, .reqValid, .reqAddr, .reqReady, .victimWay,
    .lkTagHit, .lkWay, .lkSecValid, .stb,
    .respValid, .respCode, .respWay,
    .fillReqValid, .fillReqReady, .fillReqAddr, .fillReqBeats, .fillReqBypass,
    .fillBeatValid, .fillWrEn
  );

  icl_tag_store u_store (
    .clk, .rst,
    .lkBank (reqAddr[BANK_LSB +: BANK_W]),
    .lkSet  (reqAddr[SET_LSB +: SET_W]),
    .lkTag  (reqAddr[ADDR_W-1:TAG_LSB]),
    .lkSec  (reqAddr[SEC_LSB +: SEC_W]),
    .stb, .lkTagHit, .lkWay, .lkSecValid
  );

  assign fillWrBank   = stb.markBank;
  assign fillWrSet    = stb.markSet;
  assign fillWrWay    = stb.markWay;
  assign fillWrSector = stb.markSec;
endmodule

// File: tb/tb_icl_top.sv
module tb_icl_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] cfgBase = 32'h0, cfgLimit = 32'h0FFF_FFFF;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqReady;
  logic [2:0] victimWay = '0;
  logic respValid;
  logic [1:0] respCode;
  logic [2:0] respWay;
  logic fillReqValid;
  logic fillReqReady = 1'b1;
  logic [31:0] fillReqAddr;
  logic [4:0] fillReqBeats;
  logic fillReqBypass;
  logic fillBeatValid = 1'b0;
  logic fillWrEn;
  logic [0:0] fillWrBank;
  logic [4:0] fillWrSet;
  logic [2:0] fillWrWay;
  logic [3:0] fillWrSector;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  icl_top dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] secOf(input logic [31:0] a); return a[7:4]; endfunction
  function automatic logic       bankOf(input logic [31:0] a); return a[8]; endfunction
  function automatic logic [4:0] setOf(input logic [31:0] a); return a[13:9]; endfunction

  // issue one request; results sampled one cycle after acceptance
  task automatic doReq(input logic [31:0] a, input logic [2:0] vic, input logic [1:0] expCode,
                       input logic [2:0] expWay, input string req);
    @(negedge clk);
    reqAddr = a; victimWay = vic; reqValid = 1'b1;
    #1 chk(reqReady, {req, " ready"}, reqReady, 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    chk(respValid && respCode == expCode, {req, " code"}, respCode, expCode);
    if (expCode != 2'd3) chk(respWay == expWay, {req, " way"}, respWay, expWay);
    if (expCode == 2'd2) begin
      chk(fillReqValid && !fillReqBypass && fillReqAddr == {a[31:4], 4'h0},
          {req, " fill addr"}, fillReqAddr, {a[31:4], 4'h0});
      chk(fillReqBeats == 5'd16 - 5'(secOf(a)), {req, " beats"}, fillReqBeats, 16 - secOf(a));
    end else if (expCode == 2'd3) begin
      chk(fillReqValid && fillReqBypass && fillReqBeats == 5'd1 &&
          fillReqAddr == {a[31:4], 4'h0}, {req, " bypass fetch"}, fillReqAddr, {a[31:4], 4'h0});
    end else begin
      chk(!fillReqValid, {req, " no fetch"}, fillReqValid, 0);
    end
  endtask

  task automatic probeReady(input logic [31:0] a, input bit exp, input string req);
    @(negedge clk);
    reqAddr = a;
    #1 chk(reqReady == exp, req, reqReady, exp);
  endtask

  // deliver the beats of a cacheable fill starting at sector s0
  task automatic giveBeats(input logic [31:0] a, input logic [2:0] way, input string req);
    for (int i = int'(secOf(a)); i < 16; i++) begin
      @(negedge clk);
      fillBeatValid = 1'b1;
      #1 chk(fillWrEn && fillWrSector == 4'(i) && fillWrWay == way &&
             fillWrBank == bankOf(a) && fillWrSet == setOf(a),
             req, {fillWrEn, fillWrBank, fillWrSet, fillWrWay, fillWrSector},
             {1'b1, bankOf(a), setOf(a), way, 4'(i)});
      @(posedge clk);
    end
    @(negedge clk);
    fillBeatValid = 1'b0;
  endtask

  task automatic doReset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  localparam logic [31:0] LA = 32'h0000_1234;          // sector 3
  localparam logic [31:0] LB = LA + 32'h0000_4000;     // same bank and set, new tag

  task automatic t_reset;
    #1 chk(reqReady && !respValid && !fillReqValid && !fillWrEn, "R10 reset state",
           {reqReady, respValid, fillReqValid, fillWrEn}, 4'b1000);
  endtask

  task automatic t_partial_line;
    doReq(LA, 3'd5, 2'd2, 3'd5, "R4 miss mid line");
    doReq({LA[31:8], 8'h74}, 3'd1, 2'd1, 3'd5, "R6 prefetch hit");
    probeReady(LA + 32'h0002_0000, 1'b0, "R7 other line held off");
    probeReady({LA[31:8], 8'h10}, 1'b0, "R7 sector below fill start held off");
    giveBeats(LA, 3'd5, "R5 beat strobe");
    probeReady(LA + 32'h0002_0000, 1'b1, "R7 ready after last beat");
    doReq(LA, 3'd0, 2'd0, 3'd5, "R3 hit after fill");
    doReq({LA[31:8], 8'hF0}, 3'd0, 2'd0, 3'd5, "R5 last sector hit");
    doReq({LA[31:8], 8'h00}, 3'd2, 2'd2, 3'd5, "R9 refill reuses way");
    doReq({LA[31:8], 8'h80}, 3'd2, 2'd0, 3'd5, "R9 valid sector kept during refill");
    giveBeats({LA[31:8], 8'h00}, 3'd5, "R9 refill beats");
  endtask

  task automatic t_bank;
    doReq(LA ^ 32'h100, 3'd5, 2'd2, 3'd5, "R1 other bank is separate line");
    giveBeats(LA ^ 32'h100, 3'd5, "R1 other bank beats");
    doReq(LA, 3'd0, 2'd0, 3'd5, "R1 first bank still hits");
  endtask

  task automatic t_evict;
    doReq({LB[31:8], 8'h80}, 3'd5, 2'd2, 3'd5, "R8 allocate victim");
    giveBeats({LB[31:8], 8'h80}, 3'd5, "R8 victim beats");
    doReq({LB[31:8], 8'h30}, 3'd5, 2'd2, 3'd5, "R8 old sectors cleared");
    giveBeats({LB[31:8], 8'h30}, 3'd5, "R8 refill beats");
    doReq(LA, 3'd2, 2'd2, 3'd2, "R8 evicted line misses");
    giveBeats(LA, 3'd2, "R8 beats");
  endtask

  task automatic t_bypass;
    doReq(32'h8000_001C, 3'd4, 2'd3, 3'd0, "R2 bypass");
    probeReady(LA + 32'h0004_0000, 1'b0, "R7 held off during bypass");
    @(negedge clk); fillBeatValid = 1'b1;
    #1 chk(!fillWrEn, "R2 bypass beat not written", fillWrEn, 0);
    @(posedge clk); @(negedge clk); fillBeatValid = 1'b0;
    doReq(32'h1000_0000, 3'd4, 2'd3, 3'd0, "R2 limit plus one bypasses");
    @(negedge clk); fillBeatValid = 1'b1; @(posedge clk); @(negedge clk); fillBeatValid = 1'b0;
    doReq(32'h0FFF_FFFF, 3'd4, 2'd2, 3'd4, "R2 limit is cacheable");
    giveBeats(32'h0FFF_FFFF, 3'd4, "R2 limit beats");
    cfgLimit = 32'hFFFF_FFFF;
    doReq(32'h8000_001C, 3'd6, 2'd2, 3'd6, "R2 bypass did not allocate");
    giveBeats(32'h8000_001C, 3'd6, "R2 beats");
    cfgLimit = 32'h0FFF_FFFF;
  endtask

  task automatic t_hold;
    fillReqReady = 1'b0;
    doReq(32'h0000_5A00, 3'd3, 2'd2, 3'd3, "R11 miss");
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(fillReqValid && fillReqAddr == 32'h0000_5A00, "R11 request held",
          fillReqAddr, 32'h0000_5A00);
    end
    @(negedge clk); fillReqReady = 1'b1;
    @(posedge clk); #1;
    chk(!fillReqValid, "R11 request dropped after taken", fillReqValid, 0);
    giveBeats(32'h0000_5A00, 3'd3, "R11 beats");
  endtask

  task automatic t_idle_beat;
    @(negedge clk); fillBeatValid = 1'b1;
    #1 chk(!fillWrEn, "R12 idle beat ignored", fillWrEn, 0);
    @(posedge clk); @(negedge clk); fillBeatValid = 1'b0;
    doReq(32'h0000_5A00, 3'd0, 2'd0, 3'd3, "R12 state unchanged");
  endtask

  task automatic t_reset_clear;
    doReset();
    doReq(32'h0000_5A00, 3'd1, 2'd2, 3'd1, "R10 valid bits cleared");
    doReset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_partial_line();
    t_bank();
    t_evict();
    t_bypass();
    t_hold();
    t_idle_beat();
    t_reset_clear();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule